// File: doc/BRIEF.md
# Reset and Stop-Recovery Sequencer

This block decides how long the processor core and its peripherals stay in reset after each kind of reset event. All timing is counted in cycles of the internal oscillator clock. One down-counter serves every hold. Its load value depends on the cause of the reset, the crystal option bits, and whether the event was a power-on. A stop-mode wake-up takes a short path that holds only the core and leaves the control registers untouched.

Five inputs raise a reset: the power-on detector, the brown-out detector, the external reset pin, the watchdog and the stop-mode wake-up strobe. The block drives these outputs:
- a core reset;
- a control-register reset;
- an open-drain low drive for the shared reset pin;
- a one-cycle recovery-done pulse;
- a sticky cause register that clears when it is read.

The sequencer is a seven-state machine:
- `ST_RUN`: normal operation.
- `ST_SUPPLY`: waits for both supply detectors to go low.
- `ST_OSC_WAIT`: waits for the oscillator-ready flag.
- `ST_POR_WAIT`: the extra power-on wait.
- `ST_SYS_HOLD`: the counted system hold.
- `ST_PIN_HOLD`: stretches the reset while the pin stays asserted.
- `ST_SMR_HOLD`: the short stop-recovery hold.

The transitions are:
- Any state goes to `ST_SUPPLY` on a power-on or brown-out detect.
- `ST_RUN` goes to `ST_OSC_WAIT` on a pin, watchdog or wake-up event.
- `ST_SUPPLY` goes to `ST_OSC_WAIT` once both detectors are low.
- `ST_OSC_WAIT` goes to `ST_POR_WAIT`, `ST_SYS_HOLD` or `ST_SMR_HOLD` once the oscillator is ready.
- `ST_POR_WAIT` goes to `ST_SYS_HOLD` when its count expires.
- `ST_SYS_HOLD` goes to `ST_PIN_HOLD` if the pin is still asserted at expiry, otherwise to `ST_RUN`.
- `ST_PIN_HOLD` goes to `ST_RUN` when the pin is released.
- `ST_SMR_HOLD` goes to `ST_RUN` when its count expires. A pin or watchdog event during the stop-recovery path aborts it back to `ST_OSC_WAIT` as a full system reset.

Top module: `rst_seq_top`

## Requirements
- R1: While the oscillator-ready flag is low, the block stays in reset and no hold count starts. After the first cycle in which the flag is sampled high, a system reset holds for exactly the hold length.
- R2: A watchdog pulse, or a one-cycle pin pulse, with crystal disabled and the oscillator ready, asserts core reset for exactly SYS_HOLD_CYC+1 cycles (68+1 by default). Control reset is asserted for the same cycles.
- R3: A power-on detect keeps reset asserted for as long as the detect is high. After it drops, reset lasts 1+POR_WAIT_CYC+hold cycles.
- R4: A brown-out detect keeps reset asserted for as long as the detect is high. After it drops, reset lasts 1+hold cycles, with no extra power-on wait.
- R5: With crystal enable set, the hold is chosen by the 3-bit delay field: code 0 gives 568 cycles, 1 gives 1068, 2 gives 2068 and 3 gives 5068. Codes 4 to 7 give 10068.
- R6: A stop-mode wake-up strobe asserts core reset for 1+SMR_HOLD_CYC cycles (4+1 by default). Control reset and the pin drive stay low throughout. The recovery-done pulse appears once, in the last held cycle.
- R7: If the pin is still asserted when the counted hold ends, core reset stays asserted until the pin is released. It is released in the cycle after the pin is seen low.
- R8: The open-drain pin drive is active in exactly the cycles in which control reset is asserted.
- R9: The status register bits are: bit 0 power-on, bit 1 brown-out, bit 2 pin, bit 3 watchdog, bit 4 stop recovery. A bit is set when the sequence that took that cause releases reset. Bits accumulate across resets and are cleared by a read strobe.
- R10: A pin or watchdog event during the stop-recovery path aborts the recovery without a done pulse and runs a full system hold. From the abort, control reset lasts 1+hold cycles.
- R11: While rst_n is low, core reset, control reset and pin drive are high, recovery-done is low and status is zero. The release that follows is handled as a power-on, and status then reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal oscillator clock |
| rst_n | input | 1 | Asynchronous power-up clear of the block's own flops |
| por_det | input | 1 | Power-on detector, high while supply is below threshold |
| bor_det | input | 1 | Brown-out detector, high while supply is below threshold |
| pin_rst | input | 1 | External reset pin asserted (active high, already synchronised) |
| wdt_evt | input | 1 | Watchdog reset strobe |
| smr_evt | input | 1 | Stop-mode wake-up strobe |
| osc_ready | input | 1 | Internal oscillator has started up |
| xtal_en | input | 1 | Option bit: crystal enabled, use long hold |
| xtal_dly | input | 3 | Option field selecting the crystal hold length |
| stat_rd | input | 1 | Read strobe that clears the status register |
| core_rst | output | 1 | Holds the CPU and peripherals in reset |
| ctl_rst | output | 1 | Loads control registers with reset values |
| pin_drv_lo | output | 1 | Enables open-drain low drive of the shared reset pin |
| rec_done | output | 1 | One-cycle pulse when stop recovery completes |
| rst_status | output | 5 | Sticky reset-cause register |

## Verification
A wrong state or a wrong counter load shows up directly as a wrong reset pulse length. It is visible on the cycle core reset falls, which may be as much as ten thousand cycles after the event. A stale stop-recovery flag shows at once: control reset and the pin drive disagree with core reset in the first held cycle, or the done pulse is missing or extra at release. Errors in cause logging stay hidden until the sequence releases, and then show as wrong bits in the status register.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_SUPPLY,
        ST_OSC_WAIT,
        ST_POR_WAIT,
        ST_SYS_HOLD,
        ST_PIN_HOLD,
        ST_SMR_HOLD
    } rsq_state_e;

    localparam int unsigned CAUSE_N = 5;
    localparam int unsigned CA_POR  = 0;
    localparam int unsigned CA_BOR  = 1;
    localparam int unsigned CA_PIN  = 2;
    localparam int unsigned CA_WDT  = 3;
    localparam int unsigned CA_SMR  = 4;

    localparam int unsigned XDLY_W    = 3;
    localparam int unsigned XHOLD_MAX = 10068;

    // Crystal hold lengths; undefined codes fall back to the longest.
    function automatic int unsigned xtal_hold_len(input logic [XDLY_W-1:0] code);
        int unsigned len;
        case (code)
            3'd0:    len = 568;
            3'd1:    len = 1068;
            3'd2:    len = 2068;
            3'd3:    len = 5068;
            default: len = XHOLD_MAX;
        endcase
        return len;
    endfunction

endpackage

// File: rtl/rsq_hold_counter.sv
module rsq_hold_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    // R2: an unloaded, unexpired count moves down by exactly one per cycle
    a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !expired) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/rsq_cause_log.sv
module rsq_cause_log
    import rsq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CAUSE_N-1:0] cause_set,
    input  logic               seq_done,
    input  logic               stat_rd,
    output logic [CAUSE_N-1:0] rst_status
);

    logic [CAUSE_N-1:0] pend_q;
    logic [CAUSE_N-1:0] stat_q;

    for (genvar gi = 0; gi < CAUSE_N; gi++) begin : g_bit
        localparam logic PEND_INIT = (gi == CA_POR);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pend_q[gi] <= PEND_INIT;
            end else if (seq_done) begin
                pend_q[gi] <= 1'b0;
            end else if (cause_set[gi]) begin
                pend_q[gi] <= 1'b1;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stat_q[gi] <= 1'b0;
            end else begin
                stat_q[gi] <= (stat_q[gi] & ~stat_rd) | (pend_q[gi] & seq_done);
            end
        end
    end

    assign rst_status = stat_q;

    // R9: new status bits only appear right after a release
    a_r9_set_on_release: assert property (@(posedge clk) disable iff (!rst_n)
        (|(rst_status & ~$past(rst_status))) |-> $past(seq_done));

    // R9: a read with no coinciding release leaves the register empty
    a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(stat_rd) && !$past(seq_done)) |-> (rst_status == '0));

endmodule

// File: rtl/rsq_fsm.sv
module rsq_fsm
    import rsq_pkg::*;
#(
    parameter int unsigned CNT_W        = 16,
    parameter int unsigned SYS_HOLD_CYC = 68,
    parameter int unsigned SMR_HOLD_CYC = 4,
    parameter int unsigned POR_WAIT_CYC = 1000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               por_det,
    input  logic               bor_det,
    input  logic               pin_rst,
    input  logic               wdt_evt,
    input  logic               smr_evt,
    input  logic               osc_ready,
    input  logic               xtal_en,
    input  logic [XDLY_W-1:0]  xtal_dly,
    input  logic               expired,
    output logic               cnt_load,
    output logic [CNT_W-1:0]   cnt_val,
    output logic [CAUSE_N-1:0] cause_set,
    output logic               seq_done,
    output logic               core_rst,
    output logic               ctl_rst,
    output logic               pin_drv_lo,
    output logic               rec_done
);

    localparam logic [CNT_W-1:0] SYS_LOAD = CNT_W'(SYS_HOLD_CYC - 1);
    localparam logic [CNT_W-1:0] SMR_LOAD = CNT_W'(SMR_HOLD_CYC - 1);
    localparam logic [CNT_W-1:0] POR_LOAD = CNT_W'(POR_WAIT_CYC - 1);

    rsq_state_e state_q, state_d;
    logic       smr_q, smr_d;
    logic       por_q, por_d;
    logic       smr_finish;
    logic [CNT_W-1:0] hold_load;

    always_comb begin
        if (xtal_en) begin
            hold_load = CNT_W'(xtal_hold_len(xtal_dly) - 1);
        end else begin
            hold_load = SYS_LOAD;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SUPPLY;
            smr_q   <= 1'b0;
            por_q   <= 1'b1;
        end else begin
            state_q <= state_d;
            smr_q   <= smr_d;
            por_q   <= por_d;
        end
    end

    // Next state
    always_comb begin
        state_d    = state_q;
        smr_d      = smr_q;
        por_d      = por_q;
        cnt_load   = 1'b0;
        cnt_val    = '0;
        cause_set  = '0;
        seq_done   = 1'b0;
        smr_finish = 1'b0;
        if (por_det) begin
            state_d           = ST_SUPPLY;
            smr_d             = 1'b0;
            por_d             = 1'b1;
            cause_set[CA_POR] = 1'b1;
        end else if (bor_det) begin
            state_d           = ST_SUPPLY;
            smr_d             = 1'b0;
            cause_set[CA_BOR] = 1'b1;
        end else begin
            unique case (state_q)
                ST_RUN: begin
                    if (pin_rst) begin
                        state_d           = ST_OSC_WAIT;
                        cause_set[CA_PIN] = 1'b1;
                    end else if (wdt_evt) begin
                        state_d           = ST_OSC_WAIT;
                        cause_set[CA_WDT] = 1'b1;
                    end else if (smr_evt) begin
                        state_d           = ST_OSC_WAIT;
                        smr_d             = 1'b1;
                        cause_set[CA_SMR] = 1'b1;
                    end
                end
                ST_SUPPLY: begin
                    state_d = ST_OSC_WAIT;
                end
                ST_OSC_WAIT: begin
                    if (smr_q && (pin_rst || wdt_evt)) begin
                        smr_d = 1'b0;
                        if (pin_rst) cause_set[CA_PIN] = 1'b1;
                        else         cause_set[CA_WDT] = 1'b1;
                    end else if (osc_ready) begin
                        cnt_load = 1'b1;
                        if (smr_q) begin
                            state_d = ST_SMR_HOLD;
                            cnt_val = SMR_LOAD;
                        end else if (por_q) begin
                            state_d = ST_POR_WAIT;
                            cnt_val = POR_LOAD;
                        end else begin
                            state_d = ST_SYS_HOLD;
                            cnt_val = hold_load;
                        end
                    end
                end
                ST_POR_WAIT: begin
                    if (expired) begin
                        state_d  = ST_SYS_HOLD;
                        cnt_load = 1'b1;
                        cnt_val  = hold_load;
                    end
                end
                ST_SYS_HOLD: begin
                    if (expired) begin
                        if (pin_rst) begin
                            state_d = ST_PIN_HOLD;
                        end else begin
                            state_d  = ST_RUN;
                            seq_done = 1'b1;
                            por_d    = 1'b0;
                        end
                    end
                end
                ST_PIN_HOLD: begin
                    if (!pin_rst) begin
                        state_d  = ST_RUN;
                        seq_done = 1'b1;
                        por_d    = 1'b0;
                    end
                end
                ST_SMR_HOLD: begin
                    if (pin_rst || wdt_evt) begin
                        state_d = ST_OSC_WAIT;
                        smr_d   = 1'b0;
                        if (pin_rst) cause_set[CA_PIN] = 1'b1;
                        else         cause_set[CA_WDT] = 1'b1;
                    end else if (expired) begin
                        state_d    = ST_RUN;
                        smr_d      = 1'b0;
                        seq_done   = 1'b1;
                        smr_finish = 1'b1;
                    end
                end
                default: begin
                    state_d = ST_SUPPLY;
                    smr_d   = 1'b0;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        core_rst   = (state_q != ST_RUN);
        ctl_rst    = core_rst && !smr_q;
        pin_drv_lo = core_rst && !smr_q;
        rec_done   = smr_finish;
    end

    // R1: without oscillator ready the machine does not leave the wait state
    a_r1_wait_osc: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OSC_WAIT && !osc_ready && !por_det && !bor_det)
        |=> (state_q == ST_OSC_WAIT));

    // R3 and R4: a supply detect always leads to reset next cycle
    a_r3_supply_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (por_det || bor_det) |=> core_rst);

    // R6: recovery completion never touches control state
    a_r6_no_ctl_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        rec_done |-> !ctl_rst);

    // R6: core is released right after the done pulse
    a_r6_release_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        rec_done |=> !core_rst);

    // R9: at most one cause is taken per cycle
    a_r9_one_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cause_set));

endmodule

// File: rtl/rst_seq_top.sv
module rst_seq_top
    import rsq_pkg::*;
#(
    parameter int unsigned SYS_HOLD_CYC = 68,
    parameter int unsigned SMR_HOLD_CYC = 4,
    parameter int unsigned POR_WAIT_CYC = 275000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               por_det,
    input  logic               bor_det,
    input  logic               pin_rst,
    input  logic               wdt_evt,
    input  logic               smr_evt,
    input  logic               osc_ready,
    input  logic               xtal_en,
    input  logic [2:0]         xtal_dly,
    input  logic               stat_rd,
    output logic               core_rst,
    output logic               ctl_rst,
    output logic               pin_drv_lo,
    output logic               rec_done,
    output logic [4:0]         rst_status
);

    localparam int unsigned MAX_A = (POR_WAIT_CYC > XHOLD_MAX) ? POR_WAIT_CYC : XHOLD_MAX;
    localparam int unsigned MAX_B = (SYS_HOLD_CYC > SMR_HOLD_CYC) ? SYS_HOLD_CYC : SMR_HOLD_CYC;
    localparam int unsigned MAX_V = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int unsigned CNT_W = $clog2(MAX_V + 1);

    logic               cnt_load;
    logic [CNT_W-1:0]   cnt_val;
    logic               expired;
    logic [CAUSE_N-1:0] cause_set;
    logic               seq_done;

    rsq_fsm #(
        .CNT_W       (CNT_W),
        .SYS_HOLD_CYC(SYS_HOLD_CYC),
        .SMR_HOLD_CYC(SMR_HOLD_CYC),
        .POR_WAIT_CYC(POR_WAIT_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .por_det   (por_det),
        .bor_det   (bor_det),
        .pin_rst   (pin_rst),
        .wdt_evt   (wdt_evt),
        .smr_evt   (smr_evt),
        .osc_ready (osc_ready),
        .xtal_en   (xtal_en),
        .xtal_dly  (xtal_dly),
        .expired   (expired),
        .cnt_load  (cnt_load),
        .cnt_val   (cnt_val),
        .cause_set (cause_set),
        .seq_done  (seq_done),
        .core_rst  (core_rst),
        .ctl_rst   (ctl_rst),
        .pin_drv_lo(pin_drv_lo),
        .rec_done  (rec_done)
    );

    rsq_hold_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cnt_load),
        .load_val(cnt_val),
        .expired (expired)
    );

    rsq_cause_log u_log (
        .clk       (clk),
        .rst_n     (rst_n),
        .cause_set (cause_set),
        .seq_done  (seq_done),
        .stat_rd   (stat_rd),
        .rst_status(rst_status)
    );

    // R7: a system reset is never released while the pin was asserted
    a_r7_pin_blocks_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_rst) |-> !$past(pin_rst));

    // R8: pin drive follows the control-reset window
    a_r8_pin_drive: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pin_drv_lo) |-> (ctl_rst && core_rst));

endmodule

// File: tb/rst_seq_top_tb_top.sv
module rst_seq_top_tb_top;

    localparam int unsigned SYS_N = 68;
    localparam int unsigned SMR_N = 4;
    localparam int unsigned POR_N = 300;

    logic clk = 1'b0;
    logic rst_n, por_det, bor_det, pin_rst, wdt_evt, smr_evt, osc_ready, xtal_en, stat_rd;
    logic [2:0] xtal_dly;
    logic core_rst, ctl_rst, pin_drv_lo, rec_done;
    logic [4:0] rst_status;

    always #5 clk = ~clk;

    rst_seq_top #(
        .SYS_HOLD_CYC(SYS_N),
        .SMR_HOLD_CYC(SMR_N),
        .POR_WAIT_CYC(POR_N)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .por_det(por_det), .bor_det(bor_det),
        .pin_rst(pin_rst), .wdt_evt(wdt_evt), .smr_evt(smr_evt),
        .osc_ready(osc_ready), .xtal_en(xtal_en), .xtal_dly(xtal_dly),
        .stat_rd(stat_rd), .core_rst(core_rst), .ctl_rst(ctl_rst),
        .pin_drv_lo(pin_drv_lo), .rec_done(rec_done), .rst_status(rst_status)
    );

    typedef struct {
        int    len;
        int    ctl;
        int    done;
        string req;
    } exp_t;

    exp_t sb_q[$];
    int n_chk = 0;
    int n_err = 0;

    task automatic check(input string req, input int act, input int exp_v);
        n_chk++;
        if (act != exp_v) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    // Monitor: measures each reset pulse at negedges and scores it
    bit mon_en = 1'b0;
    bit prev_rst = 1'b0;
    int m_len = 0, m_ctl = 0, m_done = 0, m_pinbad = 0;

    always @(negedge clk) begin
        if (mon_en) begin
            if (core_rst) begin
                m_len++;
                if (ctl_rst) m_ctl++;
                if (rec_done) m_done++;
                if (pin_drv_lo != ctl_rst) m_pinbad++;
            end else if (prev_rst) begin
                if (sb_q.size() == 0) begin
                    check("R2 unexpected pulse", m_len, 0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check({e.req, " length"}, m_len, e.len);
                    check({e.req, " control reset"}, m_ctl, e.ctl);
                    check({e.req, " done pulse"}, m_done, e.done);
                    check("R8 pin drive", m_pinbad, 0);
                end
                m_len = 0; m_ctl = 0; m_done = 0; m_pinbad = 0;
            end
            prev_rst = core_rst;
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic push(input int len, input int ctl, input int done, input string req);
        exp_t e;
        e.len = len; e.ctl = ctl; e.done = done; e.req = req;
        sb_q.push_back(e);
    endtask

    task automatic wait_idle();
        step();
        while (core_rst) step();
        repeat (3) step();
    endtask

    task automatic status_clear(input string req, input int exp_v);
        check({req, " status"}, int'(rst_status), exp_v);
        stat_rd = 1'b1;
        step();
        stat_rd = 1'b0;
        step();
        check("R9 read clears", int'(rst_status), 0);
    endtask

    task automatic pulse_wdt();
        wdt_evt = 1'b1; step(); wdt_evt = 1'b0;
    endtask

    initial begin
        #(10 * 150000);
        n_err++;
        n_chk++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; por_det = 1'b0; bor_det = 1'b0; pin_rst = 1'b0;
        wdt_evt = 1'b0; smr_evt = 1'b0; osc_ready = 1'b1;
        xtal_en = 1'b0; xtal_dly = 3'd0; stat_rd = 1'b0;
        repeat (4) step();
        // R11: state during block reset
        check("R11 core_rst in reset", int'(core_rst), 1);
        check("R11 ctl_rst in reset", int'(ctl_rst), 1);
        check("R11 pin drive in reset", int'(pin_drv_lo), 1);
        check("R11 rec_done in reset", int'(rec_done), 0);
        check("R11 status in reset", int'(rst_status), 0);
        rst_n = 1'b1;
        wait_idle();
        status_clear("R11 power-up", 1);
        mon_en = 1'b1;

        // R2: watchdog pulse, then pin pulse, status accumulates (R9)
        push(SYS_N + 1, SYS_N + 1, 0, "R2 watchdog");
        pulse_wdt();
        wait_idle();
        check("R9 watchdog sticky", int'(rst_status), 8);
        push(SYS_N + 1, SYS_N + 1, 0, "R2 pin pulse");
        pin_rst = 1'b1; step(); pin_rst = 1'b0;
        wait_idle();
        status_clear("R9 accumulate", 12);

        // R7: pin held past the counted hold
        push(SYS_N + 30, SYS_N + 30, 0, "R7 pin stretch");
        pin_rst = 1'b1;
        repeat (SYS_N + 30) step();
        pin_rst = 1'b0;
        wait_idle();
        status_clear("R7 pin", 4);

        // R1: oscillator late by 100 cycles
        push(100 + SYS_N, 100 + SYS_N, 0, "R1 oscillator gate");
        osc_ready = 1'b0;
        pulse_wdt();
        repeat (99) step();
        osc_ready = 1'b1;
        wait_idle();
        status_clear("R1 watchdog", 8);

        // R3: power-on detect held 10 cycles
        push(10 + 1 + POR_N + SYS_N, 10 + 1 + POR_N + SYS_N, 0, "R3 power-on");
        por_det = 1'b1;
        repeat (10) step();
        por_det = 1'b0;
        wait_idle();
        status_clear("R3 power-on", 1);

        // R4: brown-out detect held 10 cycles
        push(10 + 1 + SYS_N, 10 + 1 + SYS_N, 0, "R4 brown-out");
        bor_det = 1'b1;
        repeat (10) step();
        bor_det = 1'b0;
        wait_idle();
        status_clear("R4 brown-out", 2);

        // R5: crystal hold lengths
        xtal_en = 1'b1;
        xtal_dly = 3'd0;
        push(1 + 568, 1 + 568, 0, "R5 code 0");
        pulse_wdt();
        wait_idle();
        xtal_dly = 3'd3;
        push(1 + 5068, 1 + 5068, 0, "R5 code 3");
        pulse_wdt();
        wait_idle();
        xtal_dly = 3'd5;
        push(1 + 10068, 1 + 10068, 0, "R5 unused code");
        pulse_wdt();
        wait_idle();
        xtal_en = 1'b0;
        xtal_dly = 3'd0;
        status_clear("R5 watchdog", 8);

        // R6: stop-mode recovery
        push(1 + SMR_N, 0, 1, "R6 stop recovery");
        smr_evt = 1'b1; step(); smr_evt = 1'b0;
        wait_idle();
        status_clear("R6 stop", 16);

        // R10: watchdog aborts recovery in its hold
        push(SYS_N + 3, SYS_N + 1, 0, "R10 abort");
        smr_evt = 1'b1; step(); smr_evt = 1'b0;
        step();
        pulse_wdt();
        wait_idle();
        status_clear("R10 abort", 24);

        check("R2 scoreboard drained", sb_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule